// File: doc/BRIEF.md
# Pipelined Two-Port Synchronous Static Memory

This block is a two-port word memory in which each port runs on its own clock and can read or write any word in any cycle. Each port registers its chip selects, read/write select, lane enables, address and write data on its clock edge. A read then goes through an output register, so read data appears at the second rising edge after the request is presented. A word is two 9-bit lanes, and each lane has its own write enable.

A port has two chip selects of opposite polarity. If either one is inactive in a captured cycle, the port does nothing in that cycle and drops into a sleep state. The first selected cycle after sleep only wakes the port, so a read issued in that cycle is not driven. Output enable is active low and acts directly on the output drive; it has no effect on internal state. An asynchronous active-low reset returns both port controllers to sleep with nothing driven and leaves the stored words as they are. When both ports write overlapping lanes of the same word in the same cycle, the stored value is undefined and the block raises a collision flag instead of resolving it.

Top module: `dpram_sync`

## Requirements
- R1: A read presented at the port pins is driven on the read data outputs after the second rising edge of that port's clock, together with `drive` high.
- R2: Lane enable bit 0 writes data bits 8:0 and bit 1 writes bits 17:9. A disabled lane keeps its stored value, so a write with both enables low changes nothing.
- R3: Each port can write any word and read any word, and a word written through one port reads back through the other.
- R4: When one port reads a word in the same cycle that the other port writes it, the read returns the contents from before the write.
- R5: `wrCollide` is high in the cycle after both ports capture writes to the same address with at least one lane enabled on both. It stays low for different addresses or disjoint lanes, and with disjoint lanes each lane holds its own writer's data.
- R6: A port is deselected in a captured cycle when `selN` is 1 or `sel` is 0. In that cycle it writes nothing, and its read output is undriven (`drive` 0, data 0) two edges later.
- R7: After one or more deselected cycles, a read in the first selected cycle is not driven, and a read in the second selected cycle is driven.
- R8: `oeN` is active low and gates the output combinationally. When it is 1, `drive` is 0 and the data outputs are 0. Setting it back to 0 shows the same read data again.
- R9: While `mrstN` is 0, `drive` is 0 at once on both ports. After release, each port starts asleep as in R7, and the stored words are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clkA | input | 1 | Port A clock |
| clkB | input | 1 | Port B clock |
| mrstN | input | 1 | Asynchronous reset of the port control state, active low |
| selNA | input | 1 | Port A chip select, active low |
| selA | input | 1 | Port A chip select, active high |
| wrA | input | 1 | Port A write (1) or read (0) |
| beA | input | 2 | Port A lane write enables |
| oeNA | input | 1 | Port A output enable, active low |
| addrA | input | ADDR_W | Port A word address |
| wdataA | input | 18 | Port A write data |
| rdataA | output | 18 | Port A read data, 0 when not driven |
| driveA | output | 1 | Port A output drive active |
| selNB | input | 1 | Port B chip select, active low |
| selB | input | 1 | Port B chip select, active high |
| wrB | input | 1 | Port B write (1) or read (0) |
| beB | input | 2 | Port B lane write enables |
| oeNB | input | 1 | Port B output enable, active low |
| addrB | input | ADDR_W | Port B word address |
| wdataB | input | 18 | Port B write data |
| rdataB | output | 18 | Port B read data, 0 when not driven |
| driveB | output | 1 | Port B output drive active |
| wrCollide | output | 1 | Both ports are writing overlapping lanes of one word |

## Verification
The bench targets the cross-port case where one port reads a word while the other writes it. A design that forwards the new data there would return the written value instead of the old one. It separates overlapping from disjoint lane collisions on one word: a flag driven on address match alone would fire on the disjoint case, and a storage scheme that loses a lane would corrupt the merged word. It deselects a port through each chip select in turn and then reads. A design that skips the wake-up cycle would drive the first read after reselect, and one that ignores a select would let a deselected write reach storage. It also checks that output enable and reset act at once, without waiting for a clock edge, and that reset leaves the stored words intact.

// File: rtl/dpram_pkg.sv
package dpram_pkg;
  localparam int NUM_LANES = 2;

  typedef struct packed {
    logic                 rdEn;
    logic                 wrEn;
    logic [NUM_LANES-1:0] be;
  } portStrobe_t;
endpackage

// File: rtl/dpram_port_ctrl.sv
module dpram_port_ctrl
  import dpram_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 18
) (
  input  logic                 clk,
  input  logic                 mrstN,
  input  logic                 selN,
  input  logic                 sel,
  input  logic                 wr,
  input  logic [NUM_LANES-1:0] be,
  input  logic                 oeN,
  input  logic [ADDR_W-1:0]    addr,
  input  logic [DATA_W-1:0]    wdata,
  output portStrobe_t          st,
  output logic [ADDR_W-1:0]    addrR,
  output logic [DATA_W-1:0]    wdataR,
  output logic                 driveEn
);
  logic                 selNR, selR, wrR, awake, rdValid;
  logic [NUM_LANES-1:0] beR;
  logic                 activeR;

  // captured control, returned to the deselected state by reset
  always_ff @(posedge clk or negedge mrstN) begin
    if (!mrstN) begin
      selNR <= 1'b1;
      selR  <= 1'b0;
      wrR   <= 1'b0;
      beR   <= '0;
    end else begin
      selNR <= selN;
      selR  <= sel;
      wrR   <= wr;
      beR   <= be;
    end
  end

  always_ff @(posedge clk) begin
    addrR  <= addr;
    wdataR <= wdata;
  end

  assign activeR  = ~selNR & selR;
  assign st.wrEn  = activeR & wrR;
  assign st.rdEn  = activeR & ~wrR;
  assign st.be    = beR;

  // awake: the previous captured cycle was selected
  always_ff @(posedge clk or negedge mrstN) begin
    if (!mrstN) begin
      awake   <= 1'b0;
      rdValid <= 1'b0;
    end else begin
      awake   <= activeR;
      rdValid <= st.rdEn & awake;
    end
  end

  assign driveEn = rdValid & ~oeN;

  // R6
  desel_no_read_chk: assert property (@(posedge clk) disable iff (!mrstN)
    !activeR |=> !rdValid);
  // R7
  wake_gap_chk: assert property (@(posedge clk) disable iff (!mrstN)
    $rose(activeR) |=> !rdValid);
  // R1
  read_latency_chk: assert property (@(posedge clk) disable iff (!mrstN)
    rdValid |-> $past(st.rdEn));
endmodule

// File: rtl/dpram_xor_array.sv
module dpram_xor_array
  import dpram_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int LANE_W = 9
) (
  input  logic                           clkA,
  input  logic                           clkB,
  input  logic                           mrstN,
  input  portStrobe_t                    stA,
  input  portStrobe_t                    stB,
  input  logic [ADDR_W-1:0]              addrA,
  input  logic [ADDR_W-1:0]              addrB,
  input  logic [LANE_W*NUM_LANES-1:0]    wdataA,
  input  logic [LANE_W*NUM_LANES-1:0]    wdataB,
  output logic [LANE_W*NUM_LANES-1:0]    qA,
  output logic [LANE_W*NUM_LANES-1:0]    qB,
  output logic                           wrCollide
);
  localparam int DATA_W = LANE_W * NUM_LANES;
  localparam int DEPTH  = 1 << ADDR_W;

  // each bank has a single writer; a word is the XOR of both banks
  logic [DATA_W-1:0] bankA [DEPTH];
  logic [DATA_W-1:0] bankB [DEPTH];

  function automatic logic [DATA_W-1:0] wordAt(input logic [ADDR_W-1:0] a);
    return bankA[a] ^ bankB[a];
  endfunction

  always_ff @(posedge clkA) begin
    if (stA.wrEn) begin
      for (int g = 0; g < NUM_LANES; g++) begin
        if (stA.be[g])
          bankA[addrA][g*LANE_W +: LANE_W] <=
            wdataA[g*LANE_W +: LANE_W] ^ bankB[addrA][g*LANE_W +: LANE_W];
      end
    end
    if (stA.rdEn) qA <= wordAt(addrA);
  end

  always_ff @(posedge clkB) begin
    if (stB.wrEn) begin
      for (int g = 0; g < NUM_LANES; g++) begin
        if (stB.be[g])
          bankB[addrB][g*LANE_W +: LANE_W] <=
            wdataB[g*LANE_W +: LANE_W] ^ bankA[addrB][g*LANE_W +: LANE_W];
      end
    end
    if (stB.rdEn) qB <= wordAt(addrB);
  end

  assign wrCollide = stA.wrEn & stB.wrEn & (addrA == addrB) & (|(stA.be & stB.be));

  // R2
  full_write_store_chk: assert property (@(posedge clkA) disable iff (!mrstN)
    (stA.wrEn && (&stA.be) && !(stB.wrEn && addrB == addrA))
      |=> (wordAt($past(addrA)) == $past(wdataA)));
endmodule

// File: rtl/dpram_sync.sv
module dpram_sync
  import dpram_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int LANE_W = 9
) (
  input  logic                          clkA,
  input  logic                          clkB,
  input  logic                          mrstN,
  input  logic                          selNA,
  input  logic                          selA,
  input  logic                          wrA,
  input  logic [NUM_LANES-1:0]          beA,
  input  logic                          oeNA,
  input  logic [ADDR_W-1:0]             addrA,
  input  logic [LANE_W*NUM_LANES-1:0]   wdataA,
  output logic [LANE_W*NUM_LANES-1:0]   rdataA,
  output logic                          driveA,
  input  logic                          selNB,
  input  logic                          selB,
  input  logic                          wrB,
  input  logic [NUM_LANES-1:0]          beB,
  input  logic                          oeNB,
  input  logic [ADDR_W-1:0]             addrB,
  input  logic [LANE_W*NUM_LANES-1:0]   wdataB,
  output logic [LANE_W*NUM_LANES-1:0]   rdataB,
  output logic                          driveB,
  output logic                          wrCollide
);
  localparam int DATA_W = LANE_W * NUM_LANES;
  localparam int PORTS  = 2;

  logic [PORTS-1:0]      clkV, selNV, selV, wrV, oeNV, driveV;
  logic [NUM_LANES-1:0]  beV    [PORTS];
  logic [ADDR_W-1:0]     addrV  [PORTS];
  logic [DATA_W-1:0]     wdataV [PORTS];
  logic [ADDR_W-1:0]     addrRV [PORTS];
  logic [DATA_W-1:0]     wdRV   [PORTS];
  portStrobe_t           stV    [PORTS];
  logic [DATA_W-1:0]     qA, qB;

  assign clkV  = {clkB, clkA};
  assign selNV = {selNB, selNA};
  assign selV  = {selB, selA};
  assign wrV   = {wrB, wrA};
  assign oeNV  = {oeNB, oeNA};
  assign beV[0] = beA;      assign beV[1] = beB;
  assign addrV[0] = addrA;  assign addrV[1] = addrB;
  assign wdataV[0] = wdataA; assign wdataV[1] = wdataB;

  for (genvar p = 0; p < PORTS; p++) begin : g_port
    dpram_port_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ctrl (
      .clk(clkV[p]), .mrstN(mrstN), .selN(selNV[p]), .sel(selV[p]),
      .wr(wrV[p]), .be(beV[p]), .oeN(oeNV[p]), .addr(addrV[p]),
      .wdata(wdataV[p]), .st(stV[p]), .addrR(addrRV[p]),
      .wdataR(wdRV[p]), .driveEn(driveV[p]));
  end

  dpram_xor_array #(.ADDR_W(ADDR_W), .LANE_W(LANE_W)) u_array (
    .clkA(clkA), .clkB(clkB), .mrstN(mrstN),
    .stA(stV[0]), .stB(stV[1]), .addrA(addrRV[0]), .addrB(addrRV[1]),
    .wdataA(wdRV[0]), .wdataB(wdRV[1]), .qA(qA), .qB(qB),
    .wrCollide(wrCollide));

  assign driveA = driveV[0];
  assign driveB = driveV[1];
  assign rdataA = driveV[0] ? qA : '0;
  assign rdataB = driveV[1] ? qB : '0;
endmodule

// File: tb/dpram_sync_tb_top.sv
module dpram_sync_tb_top;
  localparam int AW = 10;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic mrstN;
  logic selNA, selA, wrA, oeNA, selNB, selB, wrB, oeNB;
  logic [1:0] beA, beB;
  logic [AW-1:0] addrA, addrB;
  logic [17:0] wdataA, wdataB, rdataA, rdataB;
  logic driveA, driveB, wrCollide;

  dpram_sync #(.ADDR_W(AW), .LANE_W(9)) dut_i (
    .clkA(clk), .clkB(clk), .mrstN(mrstN),
    .selNA(selNA), .selA(selA), .wrA(wrA), .beA(beA), .oeNA(oeNA),
    .addrA(addrA), .wdataA(wdataA), .rdataA(rdataA), .driveA(driveA),
    .selNB(selNB), .selB(selB), .wrB(wrB), .beB(beB), .oeNB(oeNB),
    .addrB(addrB), .wdataB(wdataB), .rdataB(rdataB), .driveB(driveB),
    .wrCollide(wrCollide));

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // port, wr, be, addr, data, expected read data
  typedef struct packed {
    logic port; logic wr; logic [1:0] be; logic [AW-1:0] addr;
    logic [17:0] data; logic [17:0] exp;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VECS [NV] = '{
    {1'b0, 1'b1, 2'b11, 10'd5,    18'h2A5A5, 18'h00000},
    {1'b0, 1'b0, 2'b00, 10'd5,    18'h00000, 18'h2A5A5},
    {1'b0, 1'b1, 2'b01, 10'd5,    18'h3FFFF, 18'h00000},
    {1'b1, 1'b0, 2'b00, 10'd5,    18'h00000, 18'h2A5FF},
    {1'b1, 1'b1, 2'b10, 10'd5,    18'h00000, 18'h00000},
    {1'b0, 1'b0, 2'b00, 10'd5,    18'h00000, 18'h001FF},
    {1'b0, 1'b1, 2'b00, 10'd5,    18'h3FFFF, 18'h00000},
    {1'b0, 1'b0, 2'b00, 10'd5,    18'h00000, 18'h001FF},
    {1'b1, 1'b1, 2'b11, 10'd1023, 18'h12345, 18'h00000},
    {1'b0, 1'b0, 2'b00, 10'd1023, 18'h00000, 18'h12345},
    {1'b0, 1'b1, 2'b11, 10'd0,    18'h3FFFF, 18'h00000},
    {1'b1, 1'b0, 2'b00, 10'd0,    18'h00000, 18'h3FFFF}
  };

  task automatic chk(input string tag, input logic [17:0] act, input logic [17:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic setPort(input bit p, input logic sn, input logic s, input logic w,
                         input logic [1:0] be, input logic [AW-1:0] a, input logic [17:0] d);
    if (!p) begin
      selNA = sn; selA = s; wrA = w; beA = be; addrA = a; wdataA = d;
    end else begin
      selNB = sn; selB = s; wrB = w; beB = be; addrB = a; wdataB = d;
    end
  endtask

  task automatic nop(input bit p);
    setPort(p, 1'b0, 1'b1, 1'b0, 2'b00, '0, '0);
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  initial begin
    mrstN = 1'b0; oeNA = 1'b0; oeNB = 1'b0;
    nop(0); nop(1);
    step(); step(); step();
    // R9: nothing driven in reset
    chk("R9 reset driveA", {17'd0, driveA}, 18'd0);
    chk("R9 reset driveB", {17'd0, driveB}, 18'd0);
    chk("R5 reset wrCollide", {17'd0, wrCollide}, 18'd0);
    mrstN = 1'b1;
    step(); step();

    // R1 R2 R3: vector walk
    for (int i = 0; i < NV; i++) begin
      setPort(VECS[i].port, 1'b0, 1'b1, VECS[i].wr, VECS[i].be, VECS[i].addr, VECS[i].data);
      step();
      nop(VECS[i].port);
      step();
      if (VECS[i].port) begin
        chk($sformatf("R1 vec%0d driveB", i), {17'd0, driveB}, {17'd0, ~VECS[i].wr});
        if (!VECS[i].wr) chk($sformatf("R2/R3 vec%0d rdataB", i), rdataB, VECS[i].exp);
      end else begin
        chk($sformatf("R1 vec%0d driveA", i), {17'd0, driveA}, {17'd0, ~VECS[i].wr});
        if (!VECS[i].wr) chk($sformatf("R2/R3 vec%0d rdataA", i), rdataA, VECS[i].exp);
      end
    end

    // R4: read old contents while the other port writes
    setPort(0, 1'b0, 1'b1, 1'b1, 2'b11, 10'd7, 18'h11111); step(); nop(0); step();
    setPort(0, 1'b0, 1'b1, 1'b1, 2'b11, 10'd7, 18'h22222);
    setPort(1, 1'b0, 1'b1, 1'b0, 2'b00, 10'd7, 18'h0);
    step(); nop(0); nop(1); step();
    chk("R4 same-cycle read old data", rdataB, 18'h11111);
    chk("R4 same-cycle read driven", {17'd0, driveB}, 18'd1);
    setPort(1, 1'b0, 1'b1, 1'b0, 2'b00, 10'd7, 18'h0); step(); nop(1); step();
    chk("R4 later read new data", rdataB, 18'h22222);

    // R5: overlapping lanes on one word
    setPort(0, 1'b0, 1'b1, 1'b1, 2'b11, 10'd9, 18'h0AAAA);
    setPort(1, 1'b0, 1'b1, 1'b1, 2'b11, 10'd9, 18'h15555);
    step(); nop(0); nop(1);
    chk("R5 collision flagged", {17'd0, wrCollide}, 18'd1);
    step();
    chk("R5 collision clears", {17'd0, wrCollide}, 18'd0);
    // R5: disjoint lanes on one word
    setPort(0, 1'b0, 1'b1, 1'b1, 2'b01, 10'd9, 18'h3FFFF);
    setPort(1, 1'b0, 1'b1, 1'b1, 2'b10, 10'd9, 18'h00000);
    step(); nop(0); nop(1);
    chk("R5 disjoint lanes no flag", {17'd0, wrCollide}, 18'd0);
    step();
    setPort(0, 1'b0, 1'b1, 1'b0, 2'b00, 10'd9, 18'h0); step(); nop(0); step();
    chk("R5 disjoint lanes merged", rdataA, 18'h001FF);
    // R5: different addresses
    setPort(0, 1'b0, 1'b1, 1'b1, 2'b11, 10'd20, 18'h1);
    setPort(1, 1'b0, 1'b1, 1'b1, 2'b11, 10'd21, 18'h2);
    step(); nop(0); nop(1);
    chk("R5 different addresses no flag", {17'd0, wrCollide}, 18'd0);
    step();

    // R6 R7: deselect through selN, write must be ignored
    setPort(0, 1'b1, 1'b1, 1'b1, 2'b11, 10'd5, 18'h3FFFF); step();
    nop(0); step();
    chk("R6 deselected cycle undriven", {17'd0, driveA}, 18'd0);
    chk("R6 deselected cycle data zero", rdataA, 18'h0);
    setPort(0, 1'b0, 1'b1, 1'b0, 2'b00, 10'd5, 18'h0); step();
    chk("R7 wake cycle read undriven", {17'd0, driveA}, 18'd0);
    nop(0); step();
    chk("R6 deselected write ignored", rdataA, 18'h001FF);
    chk("R7 second selected read driven", {17'd0, driveA}, 18'd1);
    // R6 R7: deselect through sel
    setPort(0, 1'b0, 1'b0, 1'b0, 2'b00, 10'd5, 18'h0); step();
    setPort(0, 1'b0, 1'b1, 1'b0, 2'b00, 10'd5, 18'h0); step();
    chk("R6 sel low undriven", {17'd0, driveA}, 18'd0);
    step();
    chk("R7 wake after sel low undriven", {17'd0, driveA}, 18'd0);
    nop(0); step();
    chk("R7 read after wake", rdataA, 18'h001FF);

    // R8: output enable gates drive at once
    setPort(0, 1'b0, 1'b1, 1'b0, 2'b00, 10'd5, 18'h0); step(); nop(0); step();
    oeNA = 1'b1; #1;
    chk("R8 oeN high undriven", {17'd0, driveA}, 18'd0);
    chk("R8 oeN high data zero", rdataA, 18'h0);
    oeNA = 1'b0; #1;
    chk("R8 oeN low restores data", rdataA, 18'h001FF);

    // R9: asynchronous reset, storage kept, ports asleep afterwards
    step();
    setPort(0, 1'b0, 1'b1, 1'b0, 2'b00, 10'd5, 18'h0); step(); nop(0); step();
    chk("R9 driven before reset", {17'd0, driveA}, 18'd1);
    mrstN = 1'b0; #1;
    chk("R9 reset drops drive at once", {17'd0, driveA}, 18'd0);
    step(); step();
    mrstN = 1'b1;
    setPort(0, 1'b0, 1'b1, 1'b0, 2'b00, 10'd5, 18'h0); step(); step(); nop(0);
    chk("R9 first read after reset undriven", {17'd0, driveA}, 18'd0);
    step();
    chk("R9 storage kept through reset", rdataA, 18'h001FF);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule